// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two descriptors from memory. The first is a segment descriptor, taken from a segment table whose base frame depends on whether the access is made in user or supervisor mode. The second is a page descriptor, taken from the page table that the segment descriptor points at. Each table fills one 4 KB page and holds 1024 four-byte descriptors. One segment descriptor therefore covers 4 MB, and one segment table covers the whole 4 GB space.

A requester presents an address, a mode and a read/write flag while the walker is idle. The walker sends one memory request at a time over a simple request/acknowledge port. It checks the valid and read-only bits at each level. On success it writes the page descriptor back with the hardware reference bit set, and also the modify bit when the access is a write. It then returns the physical address, a cache-inhibit flag and a fault code in a single-cycle response, and goes back to idle.

Top module: `xlate_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been given.
- R2: The segment descriptor is read first, at address {base, VA[31:22], 2'b00}. The base is `super_base` when `req_super` is 1 and `user_base` otherwise, sampled when the request is taken.
- R3: The page descriptor is read second, at address {segment descriptor[31:12], VA[21:12], 2'b00}. Only one memory request is outstanding at a time, and `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R4: A segment descriptor with bit 1 clear gives fault code 1 (table fault), and no page descriptor is read.
- R5: A page descriptor with bit 0 clear gives fault code 2 (page fault).
- R6: A write gives fault code 3 (protection) when bit 2 is set in the segment descriptor or in the page descriptor; reads are not affected by bit 2. Priority is table fault, then page fault, then protection.
- R7: On success the fault code is 0, `rsp_pa` = {page descriptor[31:12], VA[11:0]}, and `rsp_nocache` equals page descriptor bit 6.
- R8: After a successful lookup the page descriptor is written back to the same address with bit 3 (reference) set, and bit 4 (modify) set as well when the access is a write. The write-back is skipped when those bits are already set. A faulting lookup writes nothing.
- R9: `rsp_valid` is a one-cycle pulse, and `req_ready` is high in the following cycle. A faulting response carries `rsp_pa` = 0 and `rsp_nocache` = 0.
- R10: While reset is held, `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address to translate |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_write | input | 1 | 1 = write access |
| req_ready | output | 1 | Walker idle and able to take a request |
| user_base | input | 20 | Frame number of the user segment table |
| super_base | input | 20 | Frame number of the supervisor segment table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the descriptor |
| mem_wdata | output | 32 | Descriptor write-back data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_pa | output | 32 | Physical address, 0 on fault |
| rsp_nocache | output | 1 | Caching inhibited for the page |
| rsp_fault | output | 2 | 0 none, 1 table fault, 2 page fault, 3 protection |

## Verification
The bound checker watches several properties on every cycle. It checks that the memory port holds its request steady until acknowledge and never runs while the walker is idle. It checks that each response is a single pulse followed by readiness, that a faulting response carries a zero address, and that every write-back has the valid and reference bits set. Some behaviours depend on descriptor contents, and only the bench scenarios can show them. These are the choice of table base by mode, the order and addresses of the two reads, which fault class wins, and whether a write-back happens at all. The bench shows them with a small memory image whose descriptors mark the reference and modify bits both set and clear.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_TABLE = 2'd1,
      FLT_PAGE  = 2'd2,
      FLT_PROT  = 2'd3
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEG,
      ST_PAGE,
      ST_UPD,
      ST_DONE
   } walk_st_e;

   // descriptor bit positions decoded by hardware
   localparam int SEG_VALID_POS = 1;
   localparam int PG_VALID_POS  = 0;
   localparam int RO_POS        = 2;
   localparam int REF_POS       = 3;
   localparam int MOD_POS       = 4;
   localparam int NC_POS        = 6;

   localparam int LVL_SEG  = 0;
   localparam int LVL_PAGE = 1;

endpackage

// File: rtl/xlate_addr_form.sv
module xlate_addr_form #(
   parameter int FRAME_W = 20,
   parameter int IDX_W   = 10,
   parameter int PA_W    = 32
) (
   input  logic [FRAME_W-1:0] frame,
   input  logic [IDX_W-1:0]   index,
   output logic [PA_W-1:0]    addr
);

   localparam int SUM_W = FRAME_W + IDX_W + 2;

   generate
      if (SUM_W != PA_W) begin : g_width_bad
         $error("xlate_addr_form: frame + index + 2 must equal PA_W");
      end
   endgenerate

   assign addr = {frame, index, 2'b00};

endmodule

// File: rtl/xlate_desc_eval.sv
module xlate_desc_eval
   import xlate_pkg::*;
#(
   parameter int DESC_W = 32,
   parameter int OFF_W  = 12,
   parameter int LEVEL  = LVL_SEG
) (
   input  logic [DESC_W-1:0]       desc,
   input  logic                    is_write,
   output logic                    present,
   output logic                    write_denied,
   output logic [DESC_W-OFF_W-1:0] frame,
   output logic                    no_cache,
   output logic                    needs_update,
   output logic [DESC_W-1:0]       updated
);

   localparam logic [DESC_W-1:0] REF_MASK = DESC_W'(1) << REF_POS;
   localparam logic [DESC_W-1:0] MOD_MASK = DESC_W'(1) << MOD_POS;

   generate
      if (OFF_W <= NC_POS) begin : g_off_bad
         $error("xlate_desc_eval: offset field too narrow for flag bits");
      end
   endgenerate

   assign frame        = desc[DESC_W-1:OFF_W];
   assign write_denied = is_write & desc[RO_POS];

   generate
      if (LEVEL == LVL_SEG) begin : g_seg
         assign present      = desc[SEG_VALID_POS];
         assign no_cache     = 1'b0;
         assign needs_update = 1'b0;
         assign updated      = desc;
      end else begin : g_page
         assign present      = desc[PG_VALID_POS];
         assign no_cache     = desc[NC_POS];
         assign needs_update = ~desc[REF_POS] | (is_write & ~desc[MOD_POS]);
         assign updated      = desc | REF_MASK | (is_write ? MOD_MASK : '0);
      end
   endgenerate

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
   import xlate_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = 20,
   parameter int DESC_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_va,
   input  logic               req_write,
   input  logic [FRAME_W-1:0] base_in,
   input  logic               mem_ack,
   input  logic               seg_present,
   input  logic               seg_deny,
   input  logic [FRAME_W-1:0] seg_frame,
   input  logic               pg_present,
   input  logic               pg_deny,
   input  logic [FRAME_W-1:0] pg_frame,
   input  logic               pg_nc,
   input  logic               pg_need_upd,
   input  logic [DESC_W-1:0]  pg_updated,
   output walk_st_e           state,
   output logic [VA_W-1:0]    va_q,
   output logic               write_q,
   output logic [FRAME_W-1:0] base_q,
   output logic [FRAME_W-1:0] pt_frame_q,
   output logic [DESC_W-1:0]  upd_desc_q,
   output logic [PA_W-1:0]    pa_q,
   output logic               nc_q,
   output fault_e             fault_q
);

   logic seg_deny_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         va_q       <= '0;
         write_q    <= 1'b0;
         base_q     <= '0;
         pt_frame_q <= '0;
         seg_deny_q <= 1'b0;
         upd_desc_q <= '0;
         pa_q       <= '0;
         nc_q       <= 1'b0;
         fault_q    <= FLT_NONE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  write_q <= req_write;
                  base_q  <= base_in;
                  state   <= ST_SEG;
               end
            end
            ST_SEG: begin
               if (mem_ack) begin
                  if (!seg_present) begin
                     pa_q    <= '0;
                     nc_q    <= 1'b0;
                     fault_q <= FLT_TABLE;
                     state   <= ST_DONE;
                  end else begin
                     pt_frame_q <= seg_frame;
                     seg_deny_q <= seg_deny;
                     state      <= ST_PAGE;
                  end
               end
            end
            ST_PAGE: begin
               if (mem_ack) begin
                  if (!pg_present) begin
                     pa_q    <= '0;
                     nc_q    <= 1'b0;
                     fault_q <= FLT_PAGE;
                     state   <= ST_DONE;
                  end else if (seg_deny_q || pg_deny) begin
                     pa_q    <= '0;
                     nc_q    <= 1'b0;
                     fault_q <= FLT_PROT;
                     state   <= ST_DONE;
                  end else begin
                     pa_q       <= {pg_frame, va_q[OFF_W-1:0]};
                     nc_q       <= pg_nc;
                     fault_q    <= FLT_NONE;
                     upd_desc_q <= pg_updated;
                     state      <= pg_need_upd ? ST_UPD : ST_DONE;
                  end
               end
            end
            ST_UPD: begin
               if (mem_ack) state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
   import xlate_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 10,
   parameter int DESC_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_super,
   input  logic                  req_write,
   output logic                  req_ready,
   input  logic [PA_W-OFF_W-1:0] user_base,
   input  logic [PA_W-OFF_W-1:0] super_base,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [PA_W-1:0]       mem_addr,
   output logic [DESC_W-1:0]     mem_wdata,
   input  logic                  mem_ack,
   input  logic [DESC_W-1:0]     mem_rdata,
   output logic                  rsp_valid,
   output logic [PA_W-1:0]       rsp_pa,
   output logic                  rsp_nocache,
   output logic [1:0]            rsp_fault
);

   localparam int FRAME_W  = PA_W - OFF_W;
   localparam int SEG_LO   = OFF_W + IDX_W;
   localparam int LEVELS   = 2;

   generate
      if (VA_W != 2 * IDX_W + OFF_W) begin : g_va_bad
         $error("xlate_walker: VA_W must equal two indices plus the offset");
      end
      if (IDX_W + 2 != OFF_W) begin : g_tbl_bad
         $error("xlate_walker: one table of 4-byte descriptors must fill a page");
      end
      if (DESC_W != PA_W) begin : g_desc_bad
         $error("xlate_walker: descriptor width must match physical address width");
      end
   endgenerate

   walk_st_e             state;
   logic [VA_W-1:0]      va_q;
   logic                 write_q;
   logic [FRAME_W-1:0]   base_q;
   logic [FRAME_W-1:0]   pt_frame_q;
   logic [DESC_W-1:0]    upd_desc_q;
   logic [PA_W-1:0]      pa_q;
   logic                 nc_q;
   fault_e               fault_q;

   logic [FRAME_W-1:0]   base_sel;
   logic [FRAME_W-1:0]   lvl_frame [LEVELS];
   logic [IDX_W-1:0]     lvl_index [LEVELS];
   logic [PA_W-1:0]      lvl_addr  [LEVELS];
   logic                 lvl_present [LEVELS];
   logic                 lvl_deny    [LEVELS];
   logic [FRAME_W-1:0]   lvl_dframe  [LEVELS];
   logic                 lvl_nc      [LEVELS];
   logic                 lvl_need    [LEVELS];
   logic [DESC_W-1:0]    lvl_upd     [LEVELS];

   assign base_sel = req_super ? super_base : user_base;

   assign lvl_frame[LVL_SEG]  = base_q;
   assign lvl_index[LVL_SEG]  = va_q[VA_W-1:SEG_LO];
   assign lvl_frame[LVL_PAGE] = pt_frame_q;
   assign lvl_index[LVL_PAGE] = va_q[SEG_LO-1:OFF_W];

   for (genvar g = 0; g < LEVELS; g++) begin : g_level
      xlate_addr_form #(
         .FRAME_W (FRAME_W),
         .IDX_W   (IDX_W),
         .PA_W    (PA_W)
      ) u_addr (
         .frame (lvl_frame[g]),
         .index (lvl_index[g]),
         .addr  (lvl_addr[g])
      );

      xlate_desc_eval #(
         .DESC_W (DESC_W),
         .OFF_W  (OFF_W),
         .LEVEL  (g)
      ) u_eval (
         .desc         (mem_rdata),
         .is_write     (write_q),
         .present      (lvl_present[g]),
         .write_denied (lvl_deny[g]),
         .frame        (lvl_dframe[g]),
         .no_cache     (lvl_nc[g]),
         .needs_update (lvl_need[g]),
         .updated      (lvl_upd[g])
      );
   end

   xlate_ctrl #(
      .VA_W    (VA_W),
      .PA_W    (PA_W),
      .OFF_W   (OFF_W),
      .FRAME_W (FRAME_W),
      .DESC_W  (DESC_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_va      (req_va),
      .req_write   (req_write),
      .base_in     (base_sel),
      .mem_ack     (mem_ack),
      .seg_present (lvl_present[LVL_SEG]),
      .seg_deny    (lvl_deny[LVL_SEG]),
      .seg_frame   (lvl_dframe[LVL_SEG]),
      .pg_present  (lvl_present[LVL_PAGE]),
      .pg_deny     (lvl_deny[LVL_PAGE]),
      .pg_frame    (lvl_dframe[LVL_PAGE]),
      .pg_nc       (lvl_nc[LVL_PAGE]),
      .pg_need_upd (lvl_need[LVL_PAGE]),
      .pg_updated  (lvl_upd[LVL_PAGE]),
      .state       (state),
      .va_q        (va_q),
      .write_q     (write_q),
      .base_q      (base_q),
      .pt_frame_q  (pt_frame_q),
      .upd_desc_q  (upd_desc_q),
      .pa_q        (pa_q),
      .nc_q        (nc_q),
      .fault_q     (fault_q)
   );

   assign req_ready   = (state == ST_IDLE);
   assign mem_req     = (state == ST_SEG) || (state == ST_PAGE) || (state == ST_UPD);
   assign mem_we      = (state == ST_UPD);
   assign mem_addr    = (state == ST_SEG) ? lvl_addr[LVL_SEG] : lvl_addr[LVL_PAGE];
   assign mem_wdata   = upd_desc_q;
   assign rsp_valid   = (state == ST_DONE);
   assign rsp_pa      = pa_q;
   assign rsp_nocache = nc_q;
   assign rsp_fault   = fault_q;

endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
   parameter int PA_W   = 32,
   parameter int DESC_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PA_W-1:0]   mem_addr,
   input logic [DESC_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              rsp_valid,
   input logic [PA_W-1:0]   rsp_pa,
   input logic              rsp_nocache,
   input logic [1:0]        rsp_fault
);

   // R1
   accept_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req && !mem_we && !req_ready));

   // R1
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R8
   wb_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[3] && mem_wdata[0]));

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   // R9
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0 && !rsp_nocache));

   // R9
   rsp_idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_req);

endmodule

bind xlate_walker xlate_walker_chk #(
   .PA_W   (PA_W),
   .DESC_W (DESC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_ack     (mem_ack),
   .rsp_valid   (rsp_valid),
   .rsp_pa      (rsp_pa),
   .rsp_nocache (rsp_nocache),
   .rsp_fault   (rsp_fault)
);

// File: tb/tb_xlate_walker.sv
module tb_xlate_walker;

   typedef struct packed {
      logic [31:0] va;
      logic        sup;
      logic        wr;
      logic [1:0]  fault;
      logic [31:0] pa;
      logic        nc;
      logic [1:0]  writes;
   } vec_t;

   localparam int NVEC = 14;
   // fault: 0 none, 1 table, 2 page, 3 protection
   localparam vec_t VEC [NVEC] = '{
      '{32'h0000_0123, 1'b0, 1'b0, 2'd0, 32'h1234_5123, 1'b0, 2'd1},
      '{32'h0040_1000, 1'b0, 1'b0, 2'd1, 32'h0,         1'b0, 2'd0},
      '{32'h0000_1ABC, 1'b0, 1'b0, 2'd2, 32'h0,         1'b0, 2'd0},
      '{32'h0000_2004, 1'b0, 1'b1, 2'd3, 32'h0,         1'b0, 2'd0},
      '{32'h0000_2004, 1'b0, 1'b0, 2'd0, 32'hABCD_E004, 1'b0, 2'd1},
      '{32'h0080_0000, 1'b0, 1'b1, 2'd3, 32'h0,         1'b0, 2'd0},
      '{32'h0080_0010, 1'b0, 1'b0, 2'd0, 32'h1234_5010, 1'b0, 2'd0},
      '{32'h0000_3FFF, 1'b0, 1'b0, 2'd0, 32'h5555_5FFF, 1'b1, 2'd1},
      '{32'h0000_0FFC, 1'b1, 1'b1, 2'd0, 32'h1234_5FFC, 1'b0, 2'd1},
      '{32'h0040_1000, 1'b1, 1'b0, 2'd2, 32'h0,         1'b0, 2'd0},
      '{32'h0040_2000, 1'b1, 1'b1, 2'd3, 32'h0,         1'b0, 2'd0},
      '{32'h0000_4000, 1'b0, 1'b1, 2'd0, 32'h6666_6000, 1'b0, 2'd0},
      '{32'h0000_5008, 1'b0, 1'b0, 2'd0, 32'h7777_7008, 1'b0, 2'd0},
      '{32'h0000_5008, 1'b0, 1'b1, 2'd0, 32'h7777_7008, 1'b0, 2'd1}
   };

   localparam logic [19:0] UBASE = 20'h00001;
   localparam logic [19:0] SBASE = 20'h00002;
   localparam logic [31:0] PT_ADDR = 32'h0000_3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_super = 1'b0;
   logic        req_write = 1'b0;
   logic        req_ready;
   logic [19:0] user_base = UBASE;
   logic [19:0] super_base = SBASE;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic        rsp_nocache;
   logic [1:0]  rsp_fault;

   logic [31:0] mem [4096];
   logic [31:0] addr_log [4];
   int          log_n;
   int          wr_cnt;
   int          checks;
   int          fails;
   bit          finished;

   always #4 clk = ~clk;

   xlate_walker dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_va      (req_va),
      .req_super   (req_super),
      .req_write   (req_write),
      .req_ready   (req_ready),
      .user_base   (user_base),
      .super_base  (super_base),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .rsp_valid   (rsp_valid),
      .rsp_pa      (rsp_pa),
      .rsp_nocache (rsp_nocache),
      .rsp_fault   (rsp_fault)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory model: acknowledges every other cycle, logs addresses
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (log_n < 4) addr_log[log_n] = mem_addr;
            log_n++;
            if (mem_we) begin
               mem[mem_addr[13:2]] = mem_wdata;
               wr_cnt++;
            end else begin
               mem_rdata = mem[mem_addr[13:2]];
            end
            mem_ack = 1'b1;
         end
      end
   end

   task automatic translate(input vec_t v, input int n);
      logic [31:0] seg_exp;
      int          w0;
      bit          got;
      string       tag;
      seg_exp = {(v.sup ? SBASE : UBASE), v.va[31:22], 2'b00};
      log_n   = 0;
      w0      = wr_cnt;
      got     = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_va    = v.va;
      req_super = v.sup;
      req_write = v.wr;
      @(negedge clk);
      req_valid = 1'b0;
      // R1: busy after acceptance
      check(!req_ready, $sformatf("R1 vec%0d ready low while walking", n),
            32'(req_ready), 32'h0);
      for (int i = 0; i < 40 && !got; i++) begin
         if (rsp_valid) got = 1'b1;
         else @(negedge clk);
      end
      check(got, $sformatf("R9 vec%0d response seen", n), 32'(got), 32'h1);
      // R4 R5 R6 R7
      tag = (v.fault == 2'd1) ? "R4" : (v.fault == 2'd2) ? "R5" :
            (v.fault == 2'd3) ? "R6" : "R7";
      check(rsp_fault == v.fault, $sformatf("%s vec%0d fault code", tag, n),
            32'(rsp_fault), 32'(v.fault));
      check(rsp_pa == v.pa, $sformatf("%s vec%0d physical address", tag, n),
            rsp_pa, v.pa);
      check(rsp_nocache == v.nc, $sformatf("%s vec%0d cache inhibit", tag, n),
            32'(rsp_nocache), 32'(v.nc));
      // R2: segment read address and mode base
      check(addr_log[0] == seg_exp, $sformatf("R2 vec%0d segment address", n),
            addr_log[0], seg_exp);
      if (v.fault == 2'd1) begin
         // R4: no page read after a table fault
         check(log_n == 1, $sformatf("R4 vec%0d memory accesses", n), 32'(log_n), 32'h1);
      end else begin
         // R3: page read follows at the derived address
         check(addr_log[1] == (PT_ADDR | {20'h0, v.va[21:12], 2'b00}),
               $sformatf("R3 vec%0d page address", n), addr_log[1],
               PT_ADDR | {20'h0, v.va[21:12], 2'b00});
      end
      // R8: write-back count
      check((wr_cnt - w0) == int'(v.writes), $sformatf("R8 vec%0d write-backs", n),
            32'(wr_cnt - w0), 32'(v.writes));
      @(negedge clk);
      // R9: pulse ends, ready again
      check(req_ready && !rsp_valid, $sformatf("R9 vec%0d ready after response", n),
            {30'h0, req_ready, rsp_valid}, 32'h2);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      mem[12'h400] = 32'h0000_300A;
      mem[12'h401] = 32'h0000_0008;
      mem[12'h402] = 32'h0000_300E;
      mem[12'h800] = 32'h0000_300A;
      mem[12'h801] = 32'h0000_300A;
      mem[12'hC00] = 32'h1234_5001;
      mem[12'hC01] = 32'h0007_7000;
      mem[12'hC02] = 32'hABCD_E005;
      mem[12'hC03] = 32'h5555_5041;
      mem[12'hC04] = 32'h6666_6019;
      mem[12'hC05] = 32'h7777_7009;

      repeat (3) @(negedge clk);
      // R10: reset state
      check(req_ready, "R10 ready in reset", 32'(req_ready), 32'h1);
      check(!mem_req, "R10 no memory request in reset", 32'(mem_req), 32'h0);
      check(!rsp_valid, "R10 no response in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NVEC; k++) translate(VEC[k], k + 1);

      // R8: final descriptor images
      check(mem[12'hC00] == 32'h1234_5019, "R8 page0 reference and modify set",
            mem[12'hC00], 32'h1234_5019);
      check(mem[12'hC01] == 32'h0007_7000, "R8 invalid page untouched",
            mem[12'hC01], 32'h0007_7000);
      check(mem[12'hC02] == 32'hABCD_E00D, "R8 read-only page reference only",
            mem[12'hC02], 32'hABCD_E00D);
      check(mem[12'hC05] == 32'h7777_7019, "R8 page5 modify added",
            mem[12'hC05], 32'h7777_7019);
      check(mem[12'h400] == 32'h0000_300A, "R8 segment entry never written",
            mem[12'h400], 32'h0000_300A);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule